// File: doc/BRIEF.md
# Configuration Window Translator

This block turns plain CPU loads and stores that land in a fixed 4 MiB physical window into configuration-space requests for a PCI configuration port. The target device is not chosen by a binary field. Instead, the lowest set bit among offset bits 11 to 21 selects the device number. Offset bits 10:0 carry the function and register part unchanged. Each access carries its byte count (1, 2 or 4) through to the configuration side.

Multi-byte data is byte-reversed when it leaves for the configuration port and again when read data comes back. The `SWAP_EN` parameter can turn this reversal off. A small swizzle folds the interrupt pins of every slot onto two system interrupt lines.

A three-state controller runs the CPU handshake:

- **IDLE**: `cpu_ready` is high. A hitting, well-sized request moves the controller to ISSUE (transition *accept*). Any other request is ignored (transition *stay*).
- **ISSUE**: `cfg_req` is held with a stable address and data. `cfg_ack` moves the controller to RESP (transition *complete*).
- **RESP**: `cpu_done` pulses for one cycle with the read data, and the controller returns to IDLE (transition *release*).

Top module: `cfgwin_xlate`

## Requirements
- R1: Only addresses 0x8080_0000 to 0x80BF_FFFF are accepted. A request outside this window raises no `cfg_req`, leaves `cpu_ready` high and produces no `cpu_done`.
- R2: `cfg_addr[10:0]` equals bits 10:0 of the window offset.
- R3: `cfg_addr[14:11]` is the index i (0 to 10) of the lowest set bit among offset bits 11+i. It is 11 when none of offset bits 11 to 21 is set.
- R4: `cpu_size` is encoded as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, and is passed unchanged to `cfg_size`. Code 3 is ignored in the same way as a miss.
- R5: Write data for 1 byte is forwarded as `{24'h0, d[7:0]}`. For 2 bytes it is forwarded as `{16'h0, d[7:0], d[15:8]}`. For 4 bytes it is forwarded with all four bytes reversed.
- R6: Read data from `cfg_rdata` is formatted with the same size rules as in R5 (zero-extended, swapped) and returned on `cpu_rdata` while `cpu_done` is high.
- R7: `cpu_ready` is high in IDLE. It goes low in the cycle after acceptance. `cfg_req` stays high with a stable address and data until `cfg_ack`. `cpu_done` is high for exactly the one cycle after the ack, and `cpu_ready` returns in the cycle after that.
- R8: Only one request is outstanding. A `cpu_req` seen while `cpu_ready` is low is dropped and does not start a later transfer.
- R9: Interrupt bit `dev_irq[s*4+p]` (slot s, pin p) drives line (p + s) & 1. `irq_lo` is the OR of the line-0 sources and `irq_hi` is the OR of the line-1 sources. Both are registered with one cycle of delay.
- R10: After reset the block is in IDLE: `cpu_ready` is 1, and `cfg_req`, `cpu_done`, `irq_lo` and `irq_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Physical address |
| cpu_size | input | 2 | Size code (0 = 1, 1 = 2, 2 = 4 bytes) |
| cpu_wdata | input | 32 | Write data, low lanes used for small sizes |
| cpu_ready | output | 1 | Idle and able to accept |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Formatted read data, valid with `cpu_done` |
| cfg_req | output | 1 | Configuration request, held until ack |
| cfg_we | output | 1 | Configuration write flag |
| cfg_addr | output | 15 | Device, function and register address |
| cfg_size | output | 2 | Size code as received |
| cfg_wdata | output | 32 | Formatted write data |
| cfg_ack | input | 1 | Configuration completion |
| cfg_rdata | input | 32 | Raw configuration read data |
| dev_irq | input | 16 | Slot interrupt pins, slot s pin p at bit s*4+p |
| irq_lo | output | 1 | System interrupt for swizzle line 0 |
| irq_hi | output | 1 | System interrupt for swizzle line 1 |

## Verification
Assertions watch the handshake on every cycle. They check that a request is held stable until acked, that the CPU side is busy whenever a request is in flight, that a completion pulse follows an ack, that misses and illegal sizes never start a transfer, and that quiet interrupt inputs keep both outputs low. The address decode, the byte-lane formatting in both directions and the exact swizzle mapping need known addresses, data and pin patterns. Only the bench scenarios can show those, by comparing against values they compute themselves.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } cw_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
    localparam logic [1:0] SZ_BAD  = 2'd3;
endpackage

// File: rtl/cfgwin_addr_dec.sv
module cfgwin_addr_dec #(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_BITS = 22,
    parameter int          FN_BITS  = 11,
    localparam int         NDEV     = WIN_BITS - FN_BITS,
    localparam int         DEV_W    = $clog2(NDEV + 1),
    localparam int         CA_W     = FN_BITS + DEV_W
) (
    input  logic [31:0]     addr,
    output logic            hit,
    output logic [CA_W-1:0] cfg_addr
);
    logic [WIN_BITS-1:0] off;
    logic [DEV_W-1:0]    dev_idx;

    // Window is aligned to its own size, so compare only the upper bits.
    assign hit = (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]);
    assign off = addr[WIN_BITS-1:0];

    // Lowest set bit wins: scan from the top so lower indices override.
    always_comb begin
        dev_idx = DEV_W'(NDEV);
        for (int i = NDEV - 1; i >= 0; i--) begin
            if (off[FN_BITS + i]) begin
                dev_idx = DEV_W'(i);
            end
        end
    end

    assign cfg_addr = {dev_idx, off[FN_BITS-1:0]};
endmodule

// File: rtl/cfgwin_lane_fmt.sv
module cfgwin_lane_fmt
    import cfgwin_pkg::*;
#(
    parameter bit SWAP_EN = 1'b1
) (
    input  logic [1:0]  size,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    generate
        if (SWAP_EN) begin : g_swap
            always_comb begin
                unique case (size)
                    SZ_BYTE: dout = {24'h0, din[7:0]};
                    SZ_HALF: dout = {16'h0, din[7:0], din[15:8]};
                    SZ_WORD: dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
                    default: dout = 32'h0;
                endcase
            end
        end else begin : g_pass
            always_comb begin
                unique case (size)
                    SZ_BYTE: dout = {24'h0, din[7:0]};
                    SZ_HALF: dout = {16'h0, din[15:0]};
                    SZ_WORD: dout = din;
                    default: dout = 32'h0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/cfgwin_irq_swz.sv
module cfgwin_irq_swz #(
    parameter int N_SLOT = 4,
    parameter int N_PIN  = 4,
    localparam int N_SRC = N_SLOT * N_PIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] dev_irq,
    output logic             irq_lo,
    output logic             irq_hi
);
    logic [N_SRC-1:0] to_lo;
    logic [N_SRC-1:0] to_hi;

    generate
        for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
            for (genvar p = 0; p < N_PIN; p++) begin : g_pin
                if (((s + p) % 2) == 0) begin : g_l0
                    assign to_lo[s*N_PIN+p] = dev_irq[s*N_PIN+p];
                    assign to_hi[s*N_PIN+p] = 1'b0;
                end else begin : g_l1
                    assign to_lo[s*N_PIN+p] = 1'b0;
                    assign to_hi[s*N_PIN+p] = dev_irq[s*N_PIN+p];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_lo <= 1'b0;
            irq_hi <= 1'b0;
        end else begin
            irq_lo <= |to_lo;
            irq_hi <= |to_hi;
        end
    end

    // R9: no source active means both lines quiet one cycle later
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq == '0) |=> (!irq_lo && !irq_hi));
endmodule

// File: rtl/cfgwin_xlate.sv
module cfgwin_xlate
    import cfgwin_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h8080_0000,
    parameter int          WIN_BITS = 22,
    parameter int          FN_BITS  = 11,
    parameter int          N_SLOT   = 4,
    parameter int          N_PIN    = 4,
    parameter bit          SWAP_EN  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [1:0]  cpu_size,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic        cpu_done,
    output logic [31:0] cpu_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [FN_BITS+$clog2(WIN_BITS-FN_BITS+1)-1:0] cfg_addr,
    output logic [1:0]  cfg_size,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata,
    input  logic [N_SLOT*N_PIN-1:0] dev_irq,
    output logic        irq_lo,
    output logic        irq_hi
);
    localparam int CA_W = FN_BITS + $clog2(WIN_BITS - FN_BITS + 1);

    cw_state_e        state_q, state_d;
    logic             hit;
    logic [CA_W-1:0]  dec_addr;
    logic [31:0]      wfmt;
    logic [31:0]      rfmt;
    logic             accept;
    logic             size_ok;
    logic [31:0]      rdata_q;

    cfgwin_addr_dec #(
        .WIN_BASE (WIN_BASE),
        .WIN_BITS (WIN_BITS),
        .FN_BITS  (FN_BITS)
    ) u_dec (
        .addr     (cpu_addr),
        .hit      (hit),
        .cfg_addr (dec_addr)
    );

    cfgwin_lane_fmt #(.SWAP_EN(SWAP_EN)) u_wfmt (
        .size (cpu_size),
        .din  (cpu_wdata),
        .dout (wfmt)
    );

    cfgwin_lane_fmt #(.SWAP_EN(SWAP_EN)) u_rfmt (
        .size (cfg_size),
        .din  (cfg_rdata),
        .dout (rfmt)
    );

    cfgwin_irq_swz #(.N_SLOT(N_SLOT), .N_PIN(N_PIN)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .dev_irq (dev_irq),
        .irq_lo  (irq_lo),
        .irq_hi  (irq_hi)
    );

    assign size_ok = (cpu_size != SZ_BAD);
    assign accept  = (state_q == ST_IDLE) && cpu_req && hit && size_ok;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)  state_d = ST_ISSUE;
            ST_ISSUE: if (cfg_ack) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request and response capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_we    <= 1'b0;
            cfg_addr  <= '0;
            cfg_size  <= SZ_BYTE;
            cfg_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (accept) begin
                cfg_we    <= cpu_we;
                cfg_addr  <= dec_addr;
                cfg_size  <= cpu_size;
                cfg_wdata <= cpu_we ? wfmt : 32'h0;
            end
            if (state_q == ST_ISSUE && cfg_ack) begin
                rdata_q <= cfg_we ? 32'h0 : rfmt;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        cpu_ready = 1'b0;
        cfg_req   = 1'b0;
        cpu_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  cpu_ready = 1'b1;
            ST_ISSUE: cfg_req   = 1'b1;
            ST_RESP:  cpu_done  = 1'b1;
            default:  cpu_ready = 1'b0;
        endcase
    end

    assign cpu_rdata = rdata_q;

    // R7: request held with stable payload until acked
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_size)));

    // R7: never ready while a request is in flight
    a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> !cpu_ready);

    // R7: completion only follows an acked request
    a_r7_done_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_done) |-> $past(cfg_req && cfg_ack));

    // R8: after completion the block is idle with nothing outstanding
    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> (cpu_ready && !cfg_req && !cpu_done));

    // R1: misses never start a transfer
    a_r1_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_req && !hit) |=> !cfg_req);

    // R4: illegal size code never starts a transfer
    a_r4_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_req && cpu_size == SZ_BAD) |=> !cfg_req);

    // R3: offset bit 11 set selects device 0 in the issued address
    a_r3_low_dev: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_req && hit && size_ok && cpu_addr[FN_BITS])
            |=> (cfg_addr[CA_W-1:FN_BITS] == '0));

    // R10-style sanity: controller outputs are mutually exclusive
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({cpu_ready, cfg_req, cpu_done}));
endmodule

// File: tb/cfgwin_xlate_tb.sv
module cfgwin_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_done;
    logic [31:0] cpu_rdata;
    logic        cfg_req;
    logic        cfg_we;
    logic [14:0] cfg_addr;
    logic [1:0]  cfg_size;
    logic [31:0] cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [15:0] dev_irq = '0;
    logic        irq_lo;
    logic        irq_hi;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cfgwin_xlate u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack), .cfg_rdata(cfg_rdata),
        .dev_irq(dev_irq), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_fmt(input logic [1:0] sz, input logic [31:0] d);
        logic [31:0] r;
        r = 32'h0;
        if (sz == 2'd0) r[7:0] = d[7:0];
        else if (sz == 2'd1) begin r[15:8] = d[7:0]; r[7:0] = d[15:8]; end
        else if (sz == 2'd2) for (int b = 0; b < 4; b++) r[8*b +: 8] = d[8*(3-b) +: 8];
        return r;
    endfunction

    function automatic logic [14:0] exp_caddr(input logic [31:0] a);
        logic [3:0] dv;
        dv = 4'd11;
        for (int i = 10; i >= 0; i--) if (a[11+i]) dv = 4'(i);
        return {dv, a[10:0]};
    endfunction

    function automatic logic [1:0] exp_irq(input logic [15:0] v);
        logic lo, hi;
        lo = 1'b0; hi = 1'b0;
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 4; p++)
                if (v[s*4+p]) begin
                    if (((p + s) & 1) == 0) lo = 1'b1; else hi = 1'b1;
                end
        return {hi, lo};
    endfunction

    task automatic access(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] rd, input int lat);
        logic [14:0] ea;
        ea = exp_caddr(a);
        @(negedge clk);
        chk(cpu_ready === 1'b1, "R7 ready before accept", 32'(cpu_ready), 32'd1);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cpu_ready === 1'b0, "R7 ready low after accept", 32'(cpu_ready), 32'd0);
        chk(cfg_req === 1'b1, "R7 cfg_req issued", 32'(cfg_req), 32'd1);
        chk(cfg_addr[10:0] === ea[10:0], "R2 function/register bits", 32'(cfg_addr[10:0]), 32'(ea[10:0]));
        chk(cfg_addr[14:11] === ea[14:11], "R3 device field", 32'(cfg_addr[14:11]), 32'(ea[14:11]));
        chk(cfg_size === sz && cfg_we === we, "R4 size/dir forwarded", {29'h0, cfg_we, cfg_size}, {29'h0, we, sz});
        if (we) chk(cfg_wdata === exp_fmt(sz, wd), "R5 write data format", cfg_wdata, exp_fmt(sz, wd));
        for (int k = 0; k < lat; k++) begin
            cpu_req = 1'b1;                       // R8 noise while busy
            cpu_addr = 32'h8080_0000 | 32'($urandom & 32'h003F_FFFF);
            cpu_size = 2'd2;
            @(negedge clk);
            chk(cfg_req === 1'b1 && cfg_addr === ea, "R7 request held", {17'h0, cfg_addr}, {17'h0, ea});
            chk(cpu_ready === 1'b0, "R8 busy stays not ready", 32'(cpu_ready), 32'd0);
        end
        cpu_req = 1'b0;
        cfg_ack = 1'b1; cfg_rdata = rd;
        @(negedge clk);
        cfg_ack = 1'b0; cfg_rdata = $urandom;
        chk(cpu_done === 1'b1 && cfg_req === 1'b0, "R7 done pulse", {30'h0, cpu_done, cfg_req}, 32'd2);
        if (!we) chk(cpu_rdata === exp_fmt(sz, rd), "R6 read data format", cpu_rdata, exp_fmt(sz, rd));
        @(negedge clk);
        chk(cpu_ready === 1'b1 && cpu_done === 1'b0, "R7 ready returns", {30'h0, cpu_ready, cpu_done}, 32'd2);
        chk(cfg_req === 1'b0, "R8 busy request dropped", 32'(cfg_req), 32'd0);
    endtask

    task automatic ignored(input logic [31:0] a, input logic [1:0] sz, input string tag);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_size = sz; cpu_wdata = $urandom;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(cfg_req === 1'b0 && cpu_ready === 1'b1, tag, {30'h0, cfg_req, cpu_ready}, 32'd1);
        @(negedge clk);
        chk(cfg_req === 1'b0 && cpu_done === 1'b0, tag, {30'h0, cfg_req, cpu_done}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a;
        logic [1:0]  ex;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(cpu_ready === 1'b1 && cfg_req === 1'b0 && cpu_done === 1'b0,
            "R10 controller idle", {29'h0, cpu_ready, cfg_req, cpu_done}, 32'd4);
        chk(irq_lo === 1'b0 && irq_hi === 1'b0, "R10 irqs low", {30'h0, irq_hi, irq_lo}, 32'd0);

        // Directed corners: window edges, device decode extremes
        access(32'h8080_0000, 1'b0, 2'd2, 32'h0, 32'h1122_3344, 0);          // R3 none set -> 11
        access(32'h80BF_FFFF, 1'b1, 2'd0, 32'hDEAD_BEA5, 32'h0, 1);          // R1 top edge, R3 dev 0
        access(32'h8080_0800 | 32'h7AB, 1'b1, 2'd1, 32'h0000_A1B2, 32'h0, 2); // R3 dev 0, R5 half
        access(32'h80A0_0000, 1'b0, 2'd1, 32'h0, 32'h5566_7788, 3);          // R3 dev 10, R6 half
        access(32'h80A0_1000 | 32'h004, 1'b0, 2'd0, 32'h0, 32'hFFFF_FF9C, 0); // R3 dev 1, R6 byte
        access(32'h8090_0000, 1'b1, 2'd2, 32'h0102_0304, 32'h0, 1);          // R5 word swap

        // R1: just outside both edges, and far away
        ignored(32'h807F_FFFF, 2'd2, "R1 miss below window");
        ignored(32'h80C0_0000, 2'd2, "R1 miss above window");
        ignored(32'h0000_0CF8, 2'd0, "R1 miss low memory");
        // R4: illegal size code inside the window
        ignored(32'h8081_0000, 2'd3, "R4 size code 3 ignored");

        // Random in-window traffic, biased toward one-hot device bits
        for (int n = 0; n < 60; n++) begin
            a = 32'h8080_0000 | 32'($urandom & 32'h0000_07FF);
            if ($urandom_range(0, 3) != 0) a = a | (32'h800 << $urandom_range(0, 10));
            else a = a | (32'($urandom) & 32'h003F_F800);
            access(a, 1'($urandom), 2'($urandom_range(0, 2)), $urandom, $urandom, $urandom_range(0, 4));
        end
        // Random misses
        for (int n = 0; n < 10; n++) begin
            a = $urandom;
            if (a[31:22] == 10'h202) a[31] = 1'b0;
            ignored(a, 2'($urandom_range(0, 2)), "R1 random miss");
        end

        // R9: interrupt swizzle, directed single pins then random patterns
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 4; p++) begin
                @(negedge clk);
                dev_irq = 16'h0;
                dev_irq[s*4+p] = 1'b1;
                @(negedge clk);
                ex = exp_irq(dev_irq);
                chk({irq_hi, irq_lo} === ex, "R9 single pin mapping", {30'h0, irq_hi, irq_lo}, {30'h0, ex});
            end
        end
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            dev_irq = 16'($urandom) & 16'($urandom);
            @(negedge clk);
            ex = exp_irq(dev_irq);
            chk({irq_hi, irq_lo} === ex, "R9 random pattern", {30'h0, irq_hi, irq_lo}, {30'h0, ex});
        end
        @(negedge clk);
        dev_irq = 16'h0;
        @(negedge clk);
        chk(irq_lo === 1'b0 && irq_hi === 1'b0, "R9 release", {30'h0, irq_hi, irq_lo}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule